// File: doc/BRIEF.md
# Keyboard-Style Mailbox Channel Register Block

This block sits on the management-controller side of a host link and holds four keyboard-controller-style mailbox channels. Each channel has a byte-wide inbound data register (written by the host, read by local firmware), a byte-wide outbound data register (written by firmware, read by the host) and a status byte. The status byte carries two handshake flags: inbound-full and outbound-full. These flags change only as a side effect of data-register accesses from either side, so neither side has to write them.

Firmware reaches the block through a word-addressed local register port with read and write strobes. The host side has per-channel write strobes for inbound data and read strobes for outbound data, and it sees the status bytes directly. Each channel drives a level interrupt toward firmware. The interrupt is raised by a host write only when the channel is enabled and its inbound interrupt is armed. Channel 3 counts as enabled only when two separate control bits are both set. All channel interrupts, together with extra interrupt inputs from neighbouring functions, are latched into pending bits, and those pending bits are ORed into one summary interrupt.

Top module: `kcs_mbox_regs`

## Requirements
- R1: After reset, every register reads zero except control word 34 (byte offset 0x88), which reads the PRESET_88 parameter. All status bytes, outbound bytes, channel interrupts and the summary interrupt are zero.
- R2: Control registers live at word addresses 0, 1, 2, 3, 4, 32, 33, 34, 35 and 64. Each holds a full 32-bit value written from the local port and reads back unchanged. Channel data words are inbound 9/10/11/69, outbound 12/13/14/70 and status 15/16/17/71 for channels 1–4.
- R3: A host write strobe on a channel stores the byte in its inbound register and sets status bit 1 (inbound-full). A local read of that inbound word returns the byte in bits 7:0.
- R4: A host write raises the channel interrupt on the following clock edge only when the channel is enabled and armed. Enables are word 0 bit 5 for channel 1, word 0 bit 6 for channel 2 and word 64 bit 0 for channel 4. Arming bits are word 2 bits 1, 2 and 3 for channels 1–3 and word 64 bit 1 for channel 4.
- R5: Channel 3 is enabled only when word 0 bit 7 and word 4 bit 2 are both set. Either bit alone suppresses its interrupt.
- R6: A local read of an inbound word clears inbound-full. If inbound-full was set, the channel interrupt falls on the same clock edge.
- R7: A local write of an outbound word stores bits 7:0 and sets status bit 0 (outbound-full). A host read strobe clears it. When a local outbound write and a host read of the same channel occur in the same cycle, outbound-full ends set.
- R8: When a host write and a local read of the same inbound word occur in the same cycle, the read returns the old byte, the new byte is stored, inbound-full stays set and the channel interrupt is not dropped.
- R9: A local write of a status word replaces the whole status byte; bit 3 marks command versus data. The new byte appears on the host status output after the clock edge.
- R10: Each channel interrupt and each extra interrupt input is copied into a pending bit on every clock edge. The summary interrupt is the OR of the pending bits, so it follows its sources one cycle later.
- R11: Word addresses at or above WIN_WORDS (1024, a 4 KiB window) are ignored on write and read as zero. Unmapped words inside the window also read zero and ignore writes. Read data is zero whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lb_rd | input | 1 | Local read strobe |
| lb_wr | input | 1 | Local write strobe |
| lb_addr | input | ADDR_W | Local word address |
| lb_wdata | input | 32 | Local write data |
| lb_rdata | output | 32 | Local read data, valid in the strobe cycle |
| hst_wr | input | 4 | Host inbound write strobe, one per channel |
| hst_wdata | input | 8 | Host inbound write byte |
| hst_rd | input | 4 | Host outbound read strobe, one per channel |
| hst_odata | output | 32 | Outbound bytes, channel n at bits 8n+7:8n |
| hst_status | output | 32 | Status bytes, channel n at bits 8n+7:8n |
| ext_irq | input | NEXT | Interrupt levels from other functions |
| ch_irq | output | 4 | Per-channel interrupt levels |
| irq_any | output | 1 | Summary interrupt |

## Verification
The properties assume that the strobes are clean single-cycle pulses sampled at the clock edge, that the extra interrupt inputs are levels, and that nothing depends on the two cycles while the internal reset is still held after rst_n rises. The bench drives every input right after a falling edge, holds each strobe for exactly one cycle, waits several cycles after reset, and creates same-cycle collisions only on purpose, for the two ordering rules.

// File: rtl/kcs_mbox_pkg.sv
package kcs_mbox_pkg;

  localparam int NCH    = 4;
  localparam int LB_DW  = 32;
  localparam int BYTE_W = 8;
  localparam int NCTL   = 10;

  // control word addresses; index order below is the storage order
  localparam int CTL_WORD [NCTL] = '{0, 1, 2, 3, 4, 32, 33, 34, 35, 64};
  localparam int CTL_ENA  = 0;   // word 0
  localparam int CTL_ARM  = 2;   // word 2
  localparam int CTL_AUX  = 4;   // word 4
  localparam int CTL_PRE  = 7;   // word 34, preset at reset
  localparam int CTL_HI   = 9;   // word 64

  // per-channel enable / arm locations (control index, bit)
  localparam int ENA_REG [NCH] = '{CTL_ENA, CTL_ENA, CTL_ENA, CTL_HI};
  localparam int ENA_BIT [NCH] = '{5, 6, 7, 0};
  localparam int ARM_REG [NCH] = '{CTL_ARM, CTL_ARM, CTL_ARM, CTL_HI};
  localparam int ARM_BIT [NCH] = '{1, 2, 3, 1};
  localparam int AUX_CH      = 2;  // channel needing a second enable
  localparam int AUX_BIT     = 2;

  // status bit positions
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CD  = 3;

  function automatic int in_word(input int ch);
    case (ch)
      0:       return 9;
      1:       return 10;
      2:       return 11;
      default: return 69;
    endcase
  endfunction

  function automatic int out_word(input int ch);
    case (ch)
      0:       return 12;
      1:       return 13;
      2:       return 14;
      default: return 70;
    endcase
  endfunction

  function automatic int st_word(input int ch);
    case (ch)
      0:       return 15;
      1:       return 16;
      2:       return 17;
      default: return 71;
    endcase
  endfunction

endpackage

// File: rtl/kcs_ctl_regfile.sv
module kcs_ctl_regfile
  import kcs_mbox_pkg::*;
#(
  parameter int               ADDR_W    = 12,
  parameter logic [LB_DW-1:0] PRESET_88 = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LB_DW-1:0]  wdata,
  output logic [LB_DW-1:0]  rdata,
  output logic              hit,
  output logic [NCH-1:0]    ch_arm
);

  logic [NCTL-1:0][LB_DW-1:0] ctl_vec;
  logic [NCTL-1:0]            ctl_we;

  for (genvar k = 0; k < NCTL; k++) begin : g_ctl
    localparam logic [LB_DW-1:0] RST_V = (k == CTL_PRE) ? PRESET_88 : '0;
    logic [LB_DW-1:0] reg_q;

    assign ctl_we[k] = wr_en && (addr == ADDR_W'(CTL_WORD[k]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reg_q <= RST_V;
      else if (ctl_we[k]) reg_q <= wdata;
    end

    assign ctl_vec[k] = reg_q;
  end

  always_comb begin
    rdata = '0;
    hit   = 1'b0;
    for (int k = 0; k < NCTL; k++) begin
      if (addr == ADDR_W'(CTL_WORD[k])) begin
        rdata = ctl_vec[k];
        hit   = 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_arm
    logic en_base;
    logic en_full;
    assign en_base = ctl_vec[ENA_REG[c]][ENA_BIT[c]];
    if (c == AUX_CH) begin : g_two_bit
      assign en_full = en_base & ctl_vec[CTL_AUX][AUX_BIT];
    end else begin : g_one_bit
      assign en_full = en_base;
    end
    assign ch_arm[c] = en_full & ctl_vec[ARM_REG[c]][ARM_BIT[c]];
  end

endmodule

// File: rtl/kcs_chan.sv
module kcs_chan
  import kcs_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lb_in_rd,
  input  logic              lb_in_wr,
  input  logic              lb_out_wr,
  input  logic              lb_st_wr,
  input  logic [BYTE_W-1:0] lb_byte,
  input  logic              h_wr,
  input  logic [BYTE_W-1:0] h_byte,
  input  logic              h_rd,
  input  logic              arm,
  output logic [BYTE_W-1:0] in_q,
  output logic [BYTE_W-1:0] out_q,
  output logic [BYTE_W-1:0] st_q,
  output logic              irq_q
);

  logic [BYTE_W-1:0] in_d, st_d;
  logic              in_we, out_we, st_we, irq_d;

  always_comb begin
    in_we = h_wr | lb_in_wr;
    in_d  = h_wr ? h_byte : lb_byte;
  end

  assign out_we = lb_out_wr;

  always_comb begin
    st_we = lb_st_wr | lb_in_rd | h_wr | h_rd | lb_out_wr;
    st_d  = lb_st_wr ? lb_byte : st_q;
    if (lb_in_rd)  st_d[ST_IBF] = 1'b0;
    if (h_wr)      st_d[ST_IBF] = 1'b1;
    if (h_rd)      st_d[ST_OBF] = 1'b0;
    if (lb_out_wr) st_d[ST_OBF] = 1'b1;
  end

  always_comb begin
    irq_d = irq_q;
    if (lb_in_rd && st_q[ST_IBF] && !h_wr) irq_d = 1'b0;
    if (h_wr && arm)                       irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_q <= '0;
    else if (in_we) in_q <= in_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_we) out_q <= lb_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_we) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

endmodule

// File: rtl/kcs_irq_agg.sv
module kcs_irq_agg #(
  parameter int NSUB = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSUB-1:0] level,
  output logic            irq_any
);

  logic [NSUB-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= level;
  end

  assign irq_any = |pend_q;

endmodule

// File: rtl/kcs_mbox_regs.sv
module kcs_mbox_regs
  import kcs_mbox_pkg::*;
#(
  parameter int               ADDR_W    = 12,
  parameter int               WIN_WORDS = 1024,
  parameter int               NEXT      = 1,
  parameter logic [LB_DW-1:0] PRESET_88 = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lb_rd,
  input  logic                  lb_wr,
  input  logic [ADDR_W-1:0]     lb_addr,
  input  logic [LB_DW-1:0]      lb_wdata,
  output logic [LB_DW-1:0]      lb_rdata,
  input  logic [NCH-1:0]        hst_wr,
  input  logic [BYTE_W-1:0]     hst_wdata,
  input  logic [NCH-1:0]        hst_rd,
  output logic [NCH*BYTE_W-1:0] hst_odata,
  output logic [NCH*BYTE_W-1:0] hst_status,
  input  logic [NEXT-1:0]       ext_irq,
  output logic [NCH-1:0]        ch_irq,
  output logic                  irq_any
);

  localparam int NSUB = NCH + NEXT;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic in_win, wr_ok, rd_ok;
  assign in_win = lb_addr < ADDR_W'(WIN_WORDS);
  assign wr_ok  = lb_wr & in_win;
  assign rd_ok  = lb_rd & in_win;

  logic [LB_DW-1:0] ctl_rdata;
  logic             ctl_hit;
  logic [NCH-1:0]   ch_arm;

  kcs_ctl_regfile #(
    .ADDR_W   (ADDR_W),
    .PRESET_88(PRESET_88)
  ) u_ctl (
    .clk   (clk),
    .rst_n (rst_q_n),
    .wr_en (wr_ok),
    .addr  (lb_addr),
    .wdata (lb_wdata),
    .rdata (ctl_rdata),
    .hit   (ctl_hit),
    .ch_arm(ch_arm)
  );

  logic [NCH-1:0][BYTE_W-1:0] in_v, out_v, st_v;
  logic [NCH-1:0]             irq_v;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_in, sel_out, sel_st;
    assign sel_in  = lb_addr == ADDR_W'(in_word(c));
    assign sel_out = lb_addr == ADDR_W'(out_word(c));
    assign sel_st  = lb_addr == ADDR_W'(st_word(c));

    kcs_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .lb_in_rd (rd_ok & sel_in),
      .lb_in_wr (wr_ok & sel_in),
      .lb_out_wr(wr_ok & sel_out),
      .lb_st_wr (wr_ok & sel_st),
      .lb_byte  (lb_wdata[BYTE_W-1:0]),
      .h_wr     (hst_wr[c]),
      .h_byte   (hst_wdata),
      .h_rd     (hst_rd[c]),
      .arm      (ch_arm[c]),
      .in_q     (in_v[c]),
      .out_q    (out_v[c]),
      .st_q     (st_v[c]),
      .irq_q    (irq_v[c])
    );
  end

  logic [LB_DW-1:0] mux_data;

  always_comb begin
    mux_data = ctl_hit ? ctl_rdata : '0;
    for (int c = 0; c < NCH; c++) begin
      if (lb_addr == ADDR_W'(in_word(c)))  mux_data = {{(LB_DW-BYTE_W){1'b0}}, in_v[c]};
      if (lb_addr == ADDR_W'(out_word(c))) mux_data = {{(LB_DW-BYTE_W){1'b0}}, out_v[c]};
      if (lb_addr == ADDR_W'(st_word(c)))  mux_data = {{(LB_DW-BYTE_W){1'b0}}, st_v[c]};
    end
  end

  assign lb_rdata   = rd_ok ? mux_data : '0;
  assign hst_odata  = out_v;
  assign hst_status = st_v;
  assign ch_irq     = irq_v;

  kcs_irq_agg #(
    .NSUB(NSUB)
  ) u_agg (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .level  ({ext_irq, irq_v}),
    .irq_any(irq_any)
  );

endmodule

// File: rtl/kcs_mbox_checker.sv
module kcs_mbox_checker
  import kcs_mbox_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WIN_WORDS = 1024,
  parameter int NEXT      = 1
) (
  input logic                  clk,
  input logic                  rst_q_n,
  input logic                  lb_rd,
  input logic                  lb_wr,
  input logic [ADDR_W-1:0]     lb_addr,
  input logic [LB_DW-1:0]      lb_rdata,
  input logic [NCH-1:0]        hst_wr,
  input logic [NCH-1:0]        hst_rd,
  input logic [NCH*BYTE_W-1:0] hst_status,
  input logic [NEXT-1:0]       ext_irq,
  input logic [NCH-1:0]        ch_irq,
  input logic                  irq_any
);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_IBF_AFTER_HOST_WR: assert property (@(posedge clk) disable iff (!rst_q_n)
      hst_wr[c] |=> hst_status[c*BYTE_W + ST_IBF]);  // R3

    AST_IRQ_FROM_HOST_WR: assert property (@(posedge clk) disable iff (!rst_q_n)
      $rose(ch_irq[c]) |-> $past(hst_wr[c]));  // R4

    AST_IN_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_q_n)
      (lb_rd && lb_addr == ADDR_W'(in_word(c)) && hst_status[c*BYTE_W + ST_IBF] && !hst_wr[c])
      |=> !ch_irq[c]);  // R6

    AST_HOST_RD_CLEARS_OBF: assert property (@(posedge clk) disable iff (!rst_q_n)
      (hst_rd[c] && !(lb_wr && lb_addr == ADDR_W'(out_word(c))))
      |=> !hst_status[c*BYTE_W + ST_OBF]);  // R7
  end

  AST_SUMMARY_RISES: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|{ext_irq, ch_irq}) |=> irq_any);  // R10

  AST_SUMMARY_FALLS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(|{ext_irq, ch_irq}) |=> !irq_any);  // R10

  AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lb_addr >= ADDR_W'(WIN_WORDS)) |-> (lb_rdata == '0));  // R11

endmodule

bind kcs_mbox_regs kcs_mbox_checker #(
  .ADDR_W   (ADDR_W),
  .WIN_WORDS(WIN_WORDS),
  .NEXT     (NEXT)
) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .lb_rd     (lb_rd),
  .lb_wr     (lb_wr),
  .lb_addr   (lb_addr),
  .lb_rdata  (lb_rdata),
  .hst_wr    (hst_wr),
  .hst_rd    (hst_rd),
  .hst_status(hst_status),
  .ext_irq   (ext_irq),
  .ch_irq    (ch_irq),
  .irq_any   (irq_any)
);

// File: tb/kcs_mbox_regs_test.sv
`timescale 1ns/1ps
module kcs_mbox_regs_test;

  localparam int          AW     = 12;
  localparam logic [31:0] PRESET = 32'h00C0_FFEE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lb_rd, lb_wr;
  logic [AW-1:0] lb_addr;
  logic [31:0] lb_wdata, lb_rdata;
  logic [3:0]  hst_wr, hst_rd;
  logic [7:0]  hst_wdata;
  logic [31:0] hst_odata, hst_status;
  logic [0:0]  ext_irq;
  logic [3:0]  ch_irq;
  logic        irq_any;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  kcs_mbox_regs #(.ADDR_W(AW), .WIN_WORDS(1024), .NEXT(1), .PRESET_88(PRESET)) uut (
    .clk(clk), .rst_n(rst_n), .lb_rd(lb_rd), .lb_wr(lb_wr), .lb_addr(lb_addr),
    .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .hst_wr(hst_wr), .hst_wdata(hst_wdata),
    .hst_rd(hst_rd), .hst_odata(hst_odata), .hst_status(hst_status),
    .ext_irq(ext_irq), .ch_irq(ch_irq), .irq_any(irq_any)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (lb_rd) begin
      if (exp_q.size() == 0) check("read without expectation", lb_rdata, 32'hx);
      else check(tag_q.pop_front(), lb_rdata, exp_q.pop_front());
    end
  end

  task automatic lb_read(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    lb_rd = 1'b1; lb_addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    lb_rd = 1'b0;
  endtask

  task automatic lb_write(input int a, input logic [31:0] d);
    @(negedge clk);
    lb_wr = 1'b1; lb_addr = AW'(a); lb_wdata = d;
    @(negedge clk);
    lb_wr = 1'b0;
  endtask

  task automatic host_write(input int c, input logic [7:0] b);
    @(negedge clk);
    hst_wr = '0; hst_wr[c] = 1'b1; hst_wdata = b;
    @(negedge clk);
    hst_wr = '0;
  endtask

  task automatic host_read(input int c);
    @(negedge clk);
    hst_rd = '0; hst_rd[c] = 1'b1;
    @(negedge clk);
    hst_rd = '0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lb_rd = 0; lb_wr = 0; lb_addr = '0; lb_wdata = '0;
    hst_wr = '0; hst_rd = '0; hst_wdata = '0; ext_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    lb_read(34, PRESET, "R1 preset word");
    lb_read(0, 32'h0, "R1 control zero");
    check("R1 status", hst_status, 32'h0);
    check("R1 outbound", hst_odata, 32'h0);
    check("R1 channel irq", {28'h0, ch_irq}, 32'h0);
    check("R1 summary irq", {31'h0, irq_any}, 32'h0);

    // R2 control map
    lb_write(0, 32'h0000_0020);
    lb_write(2, 32'h0000_0002);
    lb_write(35, 32'hDEAD_BEEF);
    lb_read(0, 32'h0000_0020, "R2 word 0");
    lb_read(2, 32'h0000_0002, "R2 word 2");
    lb_read(35, 32'hDEAD_BEEF, "R2 word 35");

    // R3/R4 channel 1 armed
    host_write(0, 8'h5A);
    check("R3 ch1 inbound-full", {31'h0, hst_status[1]}, 32'h1);
    check("R4 ch1 irq", {31'h0, ch_irq[0]}, 32'h1);
    @(negedge clk);
    check("R10 summary high", {31'h0, irq_any}, 32'h1);
    lb_read(9, 32'h0000_005A, "R3 ch1 inbound data");
    check("R6 ch1 inbound-full cleared", {31'h0, hst_status[1]}, 32'h0);
    check("R6 ch1 irq dropped", {31'h0, ch_irq[0]}, 32'h0);
    @(negedge clk);
    check("R10 summary low", {31'h0, irq_any}, 32'h0);

    // R4 channel 2 enabled, not armed
    lb_write(0, 32'h0000_0060);
    host_write(1, 8'h77);
    check("R3 ch2 inbound-full", {31'h0, hst_status[9]}, 32'h1);
    check("R4 ch2 unarmed no irq", {31'h0, ch_irq[1]}, 32'h0);
    lb_read(10, 32'h0000_0077, "R3 ch2 inbound data");

    // R5 channel 3 needs two enables
    lb_write(0, 32'h0000_00E0);
    lb_write(2, 32'h0000_000E);
    host_write(2, 8'h11);
    check("R5 ch3 one enable no irq", {31'h0, ch_irq[2]}, 32'h0);
    lb_read(11, 32'h0000_0011, "R5 ch3 inbound data");
    lb_write(4, 32'h0000_0004);
    host_write(2, 8'h12);
    check("R5 ch3 both enables irq", {31'h0, ch_irq[2]}, 32'h1);
    lb_read(11, 32'h0000_0012, "R6 ch3 inbound data");
    check("R6 ch3 irq dropped", {31'h0, ch_irq[2]}, 32'h0);

    // R4 channel 4 on word 64
    lb_write(64, 32'h0000_0003);
    host_write(3, 8'hC4);
    check("R4 ch4 irq", {31'h0, ch_irq[3]}, 32'h1);
    lb_read(69, 32'h0000_00C4, "R3 ch4 inbound data");
    check("R6 ch4 irq dropped", {31'h0, ch_irq[3]}, 32'h0);

    // R7 outbound path
    lb_write(12, 32'hFFFF_FF33);
    check("R7 ch1 outbound-full", {31'h0, hst_status[0]}, 32'h1);
    check("R7 ch1 outbound byte", {24'h0, hst_odata[7:0]}, 32'h33);
    lb_read(12, 32'h0000_0033, "R7 ch1 outbound readback");
    host_read(0);
    check("R7 ch1 outbound-full cleared", {31'h0, hst_status[0]}, 32'h0);
    @(negedge clk);
    lb_wr = 1'b1; lb_addr = AW'(13); lb_wdata = 32'h44; hst_rd = 4'b0010;
    @(negedge clk);
    lb_wr = 1'b0; hst_rd = '0;
    check("R7 collision outbound-full set", {31'h0, hst_status[8]}, 32'h1);

    // R8 host write vs local read collision
    host_write(0, 8'hA1);
    @(negedge clk);
    lb_rd = 1'b1; lb_addr = AW'(9); hst_wr = 4'b0001; hst_wdata = 8'hB2;
    exp_q.push_back(32'h0000_00A1); tag_q.push_back("R8 collision returns old byte");
    @(negedge clk);
    lb_rd = 1'b0; hst_wr = '0;
    check("R8 inbound-full kept", {31'h0, hst_status[1]}, 32'h1);
    check("R8 irq kept", {31'h0, ch_irq[0]}, 32'h1);
    lb_read(9, 32'h0000_00B2, "R8 new byte stored");
    check("R8 inbound-full cleared after", {31'h0, hst_status[1]}, 32'h0);

    // R9 status write
    lb_write(15, 32'h0000_0008);
    check("R9 status byte", {24'h0, hst_status[7:0]}, 32'h08);
    lb_read(15, 32'h0000_0008, "R9 status readback");

    // R11 window
    lb_write(1024, 32'hFFFF_FFFF);
    lb_read(0, 32'h0000_00E0, "R11 outside write ignored");
    lb_read(1024, 32'h0, "R11 outside reads zero");
    lb_write(5, 32'h1234_5678);
    lb_read(5, 32'h0, "R11 unmapped reads zero");
    @(negedge clk); #1;
    check("R11 idle read data zero", lb_rdata, 32'h0);

    // R10 extra interrupt input
    check("R10 no channel irq", {28'h0, ch_irq}, 32'h0);
    @(negedge clk);
    ext_irq = 1'b1;
    @(negedge clk);
    check("R10 external raises summary", {31'h0, irq_any}, 32'h1);
    ext_irq = 1'b0;
    @(negedge clk);
    check("R10 external clears summary", {31'h0, irq_any}, 32'h0);

    repeat (2) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule